// File: doc/BRIEF.md
# Byte-Interleaved TDM Slot Demultiplexer

This block sits on the receive side of a terminal that is attached to a 48 kbit/s multiplexed serial link. Each clock cycle carries exactly one line bit. On every cycle the block samples the receive data line, the indication line and an active-low frame marker line. It uses the marker to find the frame boundary. It then cuts the bit stream into fixed-width time slots, each holding consecutive bits of one subscriber channel. For every slot it presents the assembled byte together with the slot number, the slot's phase (one of five 9600 bit/s groups) and the indication level seen for that slot.

Two parameters set the byte width and the frame length. A byte width of 6 is paired with a frame of 480 or 120 bits, and a byte width of 8 with a frame of 640 bits. Two fault inputs let line-monitoring logic declare the data line or the indication line broken. The block then substitutes the safe levels: data zero and indication OFF.

Top module: `tdm_slot_demux`

## Requirements
- R1: After reset, `byte_valid`, `locked` and `align_err` are all 0.
- R2: The frame marker is `frame_n` = 0 during the final bit of a frame. `locked` rises in the cycle after a second marker is sampled exactly FRAME_BITS bits after the first. In lock, the bit sampled right after a marker is bit 0 of slot 0.
- R3: Each slot holds BYTE_W bits, and the first bit sampled goes into `byte_data[0]`. `byte_valid` is high for exactly one cycle, in the cycle after the slot's last bit is sampled. It pulses only for slots whose last bit was sampled while locked, and it is 0 on every other cycle.
- R4: `slot_idx` counts 0 to FRAME_BITS/BYTE_W-1 within a frame and then wraps. `phase_idx` equals `slot_idx` mod 5.
- R5: `slot_ind` reports the level of `rx_ind` sampled on the first bit of the slot (1 = ON). Levels on the other bits of the slot have no effect.
- R6: Every data bit sampled while `rx_fault` = 1 is recorded as 0.
- R7: While `ind_fault` = 1 at a slot's first bit, `slot_ind` for that slot is 0 (OFF).
- R8: While locked, one faulty boundary event is tolerated. A faulty event is a marker at a non-final bit, or no marker at the final bit. A correct marker at the final bit clears the tolerance count.
- R9: A second faulty boundary event, with no correct marker in between, drops `locked` in the cycle after it is sampled. It also sets `align_err`, which then stays 1 until reset.
- R10: While waiting for the confirming marker, a marker at a non-final bit restarts alignment from that marker.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 1 | Serial receive data |
| rx_ind | input | 1 | Indication line, 1 = ON |
| frame_n | input | 1 | Active-low frame marker, low on the last bit of a frame |
| rx_fault | input | 1 | Receive data line declared faulty |
| ind_fault | input | 1 | Indication line declared faulty |
| byte_valid | output | 1 | One-cycle strobe for a completed slot byte |
| byte_data | output | BYTE_W | Slot byte, first received bit in bit 0 |
| slot_idx | output | SLOT_W | Slot number within the frame |
| phase_idx | output | 3 | Phase group of the slot, 0 to 4 |
| slot_ind | output | 1 | Indication level for the slot |
| locked | output | 1 | Frame alignment held |
| align_err | output | 1 | Sticky flag set when alignment is lost |

## Verification
The bench sweeps every slot of a 6-bit, 120-bit-frame configuration over several frames, each with a distinct byte pattern. An off-by-one in the realignment would shift every byte and slot number, and a reversed bit order would show up in each mismatched byte. The indication line is deliberately flipped on every bit except the first of each slot, so a design that samples it late reports the wrong level. The bench injects a stray marker, then two missing markers, then a stray marker during confirmation. A design with no tolerance, too much tolerance or no restart would lock, drop lock or flag an error in the wrong frame. Fault windows drive the data line to all ones and the indication line ON, so a fault input that is ignored produces visibly wrong bytes or levels.

// File: rtl/tdm_demux_pkg.sv
package tdm_demux_pkg;
    localparam int NUM_PHASES = 5;
    localparam int PHASE_W    = 3;

    typedef enum logic [1:0] {
        LK_HUNT  = 2'd0,
        LK_CHECK = 2'd1,
        LK_SYNC  = 2'd2
    } lock_state_t;
endpackage

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter #(
    parameter int BYTE_W = 8,
    parameter int SLOTS  = 80
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    restart,
    output logic [$clog2(BYTE_W)-1:0]               bit_pos,
    output logic [$clog2(SLOTS)-1:0]                slot_pos,
    output logic [tdm_demux_pkg::PHASE_W-1:0]       phase_pos,
    output logic                                    frame_end
);
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(BYTE_W - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
    localparam logic [tdm_demux_pkg::PHASE_W-1:0] LAST_PHASE =
        tdm_demux_pkg::PHASE_W'(tdm_demux_pkg::NUM_PHASES - 1);

    typedef struct packed {
        logic [BIT_W-1:0]                   bitc;
        logic [SLOT_W-1:0]                  slot;
        logic [tdm_demux_pkg::PHASE_W-1:0]  phase;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (cnt_q.bitc == LAST_BIT) begin
            cnt_d.bitc = '0;
            if (cnt_q.slot == LAST_SLOT) begin
                cnt_d.slot  = '0;
                cnt_d.phase = '0;
            end else begin
                cnt_d.slot  = cnt_q.slot + 1'b1;
                cnt_d.phase = (cnt_q.phase == LAST_PHASE) ? '0 : cnt_q.phase + 1'b1;
            end
        end else begin
            cnt_d.bitc = cnt_q.bitc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign bit_pos   = cnt_q.bitc;
    assign slot_pos  = cnt_q.slot;
    assign phase_pos = cnt_q.phase;
    assign frame_end = (cnt_q.bitc == LAST_BIT) && (cnt_q.slot == LAST_SLOT);
endmodule

// File: rtl/tdm_frame_lock.sv
module tdm_frame_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic marker,
    input  logic frame_end,
    output logic restart,
    output logic in_sync,
    output logic lost_err
);
    import tdm_demux_pkg::*;

    typedef struct packed {
        lock_state_t state;
        logic        miss;
        logic        err;
    } lock_t;

    lock_t lk_d, lk_q;
    logic  bad_edge;

    always_comb begin
        lk_d     = lk_q;
        restart  = 1'b0;
        bad_edge = (frame_end && !marker) || (!frame_end && marker);
        unique case (lk_q.state)
            LK_HUNT: begin
                if (marker) begin
                    restart    = 1'b1;
                    lk_d.state = LK_CHECK;
                end
            end
            LK_CHECK: begin
                if (frame_end) begin
                    lk_d.state = marker ? LK_SYNC : LK_HUNT;
                    lk_d.miss  = 1'b0;
                end else if (marker) begin
                    restart = 1'b1;
                end
            end
            LK_SYNC: begin
                if (bad_edge) begin
                    if (lk_q.miss) begin
                        lk_d.state = LK_HUNT;
                        lk_d.miss  = 1'b0;
                        lk_d.err   = 1'b1;
                    end else begin
                        lk_d.miss = 1'b1;
                    end
                end else if (frame_end) begin
                    lk_d.miss = 1'b0;
                end
            end
            default: lk_d.state = LK_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lk_q <= '{state: LK_HUNT, miss: 1'b0, err: 1'b0};
        else        lk_q <= lk_d;
    end

    assign in_sync  = (lk_q.state == LK_SYNC);
    assign lost_err = lk_q.err;
endmodule

// File: rtl/tdm_byte_assembler.sv
module tdm_byte_assembler #(
    parameter int BYTE_W = 8,
    parameter int SLOTS  = 80
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_sync,
    input  logic [$clog2(BYTE_W)-1:0]           bit_pos,
    input  logic [$clog2(SLOTS)-1:0]            slot_pos,
    input  logic [tdm_demux_pkg::PHASE_W-1:0]   phase_pos,
    input  logic                                rx_data,
    input  logic                                rx_ind,
    input  logic                                rx_fault,
    input  logic                                ind_fault,
    output logic                                out_valid,
    output logic [BYTE_W-1:0]                   out_data,
    output logic [$clog2(SLOTS)-1:0]            out_slot,
    output logic [tdm_demux_pkg::PHASE_W-1:0]   out_phase,
    output logic                                out_ind
);
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    typedef struct packed {
        logic [BYTE_W-1:0]                  shreg;
        logic                               ind_smp;
        logic                               valid;
        logic [BYTE_W-1:0]                  data;
        logic [SLOT_W-1:0]                  slot;
        logic [tdm_demux_pkg::PHASE_W-1:0]  phase;
        logic                               ind;
    } asm_t;

    asm_t as_d, as_q;

    always_comb begin
        as_d                 = as_q;
        as_d.valid           = 1'b0;
        as_d.shreg[bit_pos]  = rx_data & ~rx_fault;
        if (bit_pos == '0) begin
            as_d.ind_smp = rx_ind & ~ind_fault;
        end
        if (in_sync && bit_pos == LAST_BIT) begin
            as_d.valid = 1'b1;
            as_d.data  = as_d.shreg;
            as_d.slot  = slot_pos;
            as_d.phase = phase_pos;
            as_d.ind   = as_d.ind_smp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) as_q <= '0;
        else        as_q <= as_d;
    end

    assign out_valid = as_q.valid;
    assign out_data  = as_q.data;
    assign out_slot  = as_q.slot;
    assign out_phase = as_q.phase;
    assign out_ind   = as_q.ind;
endmodule

// File: rtl/tdm_slot_demux.sv
module tdm_slot_demux #(
    parameter int BYTE_W     = 8,
    parameter int FRAME_BITS = 640,
    localparam int SLOTS     = FRAME_BITS / BYTE_W,
    localparam int SLOT_W    = $clog2(SLOTS)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               rx_data,
    input  logic                               rx_ind,
    input  logic                               frame_n,
    input  logic                               rx_fault,
    input  logic                               ind_fault,
    output logic                               byte_valid,
    output logic [BYTE_W-1:0]                  byte_data,
    output logic [SLOT_W-1:0]                  slot_idx,
    output logic [tdm_demux_pkg::PHASE_W-1:0]  phase_idx,
    output logic                               slot_ind,
    output logic                               locked,
    output logic                               align_err
);
    localparam int BIT_W = $clog2(BYTE_W);

    logic                               restart;
    logic                               frame_end;
    logic [BIT_W-1:0]                   bit_pos;
    logic [SLOT_W-1:0]                  slot_pos;
    logic [tdm_demux_pkg::PHASE_W-1:0]  phase_pos;

    tdm_slot_counter #(.BYTE_W(BYTE_W), .SLOTS(SLOTS)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .bit_pos   (bit_pos),
        .slot_pos  (slot_pos),
        .phase_pos (phase_pos),
        .frame_end (frame_end)
    );

    tdm_frame_lock u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .marker    (~frame_n),
        .frame_end (frame_end),
        .restart   (restart),
        .in_sync   (locked),
        .lost_err  (align_err)
    );

    tdm_byte_assembler #(.BYTE_W(BYTE_W), .SLOTS(SLOTS)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_sync   (locked),
        .bit_pos   (bit_pos),
        .slot_pos  (slot_pos),
        .phase_pos (phase_pos),
        .rx_data   (rx_data),
        .rx_ind    (rx_ind),
        .rx_fault  (rx_fault),
        .ind_fault (ind_fault),
        .out_valid (byte_valid),
        .out_data  (byte_data),
        .out_slot  (slot_idx),
        .out_phase (phase_idx),
        .out_ind   (slot_ind)
    );
endmodule

// File: rtl/tdm_slot_demux_chk.sv
module tdm_slot_demux_chk #(
    parameter int BYTE_W     = 8,
    parameter int FRAME_BITS = 640,
    localparam int SLOTS     = FRAME_BITS / BYTE_W,
    localparam int SLOT_W    = $clog2(SLOTS)
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               byte_valid,
    input logic [SLOT_W-1:0]                  slot_idx,
    input logic [tdm_demux_pkg::PHASE_W-1:0]  phase_idx,
    input logic                               locked,
    input logic                               align_err
);
    // R3
    valid_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> $past(locked));

    // R3
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    // R4
    phase_of_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> (32'(phase_idx) == 32'(slot_idx) % 5));

    // R4
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> (32'(slot_idx) < SLOTS));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |=> align_err);

    // R9
    loss_flags_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> align_err);
endmodule

bind tdm_slot_demux tdm_slot_demux_chk #(.BYTE_W(BYTE_W), .FRAME_BITS(FRAME_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .slot_idx   (slot_idx),
    .phase_idx  (phase_idx),
    .locked     (locked),
    .align_err  (align_err)
);

// File: tb/tdm_slot_demux_bench.sv
module tdm_slot_demux_bench;
    localparam int BW    = 6;
    localparam int FB    = 120;
    localparam int NS    = FB / BW;
    localparam int SW    = $clog2(NS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_data = 1'b0, rx_ind = 1'b0, frame_n = 1'b1, rx_fault = 1'b0, ind_fault = 1'b0;
    logic          byte_valid, slot_ind, locked, align_err;
    logic [BW-1:0] byte_data;
    logic [SW-1:0] slot_idx;
    logic [2:0]    phase_idx;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    tdm_slot_demux #(.BYTE_W(BW), .FRAME_BITS(FB)) u_tdm_slot_demux (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_ind(rx_ind), .frame_n(frame_n),
        .rx_fault(rx_fault), .ind_fault(ind_fault), .byte_valid(byte_valid),
        .byte_data(byte_data), .slot_idx(slot_idx), .phase_idx(phase_idx),
        .slot_ind(slot_ind), .locked(locked), .align_err(align_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int pat_byte(input int f, input int s);
        return (f * 37 + s * 11 + 3) % (1 << BW);
    endfunction

    function automatic bit pat_ind(input int f, input int s);
        return 1'((f + s) & 1);
    endfunction

    // One line bit; outputs checked one time unit after the sampling edge.
    task automatic drive_bit(input bit d, input bit ind, input bit mk, input bit rf, input bit ifl);
        @(negedge clk);
        rx_data = d; rx_ind = ind; frame_n = ~mk; rx_fault = rf; ind_fault = ifl;
        @(posedge clk);
        #1;
    endtask

    task automatic send_idle(input int n, input int m1, input int m2);
        for (int i = 0; i < n; i++) begin
            drive_bit(1'b1, 1'b1, (i == m1) || (i == m2), 1'b0, 1'b0);
            check(byte_valid == 1'b0, "R3 no strobe before lock", int'(byte_valid), 0);
        end
    endtask

    task automatic send_frame(input int f, input bit exp_out, input bit end_mk,
                              input int extra_pos, input int rf_lo, input int rf_hi,
                              input bit ifl);
        for (int s = 0; s < NS; s++) begin
            bit rf;
            int eb;
            rf = (s >= rf_lo) && (s <= rf_hi);
            eb = rf ? 0 : pat_byte(f, s);
            for (int b = 0; b < BW; b++) begin
                int  pos;
                bit  d, ind, mk;
                pos = s * BW + b;
                d   = rf ? 1'b1 : 1'((pat_byte(f, s) >> b) & 1);
                ind = ifl ? 1'b1 : ((b == 0) ? pat_ind(f, s) : ~pat_ind(f, s));
                mk  = ((pos == FB - 1) && end_mk) || (pos == extra_pos);
                drive_bit(d, ind, mk, rf, ifl);
                if (exp_out && b == BW - 1) begin
                    check(byte_valid == 1'b1, "R3 strobe after last bit", int'(byte_valid), 1);
                    if (rf) check(int'(byte_data) == 0, "R6 faulty data zeroed", int'(byte_data), 0);
                    else    check(int'(byte_data) == eb, "R3 byte assembly LSB first", int'(byte_data), eb);
                    check(int'(slot_idx) == s, "R4 slot index", int'(slot_idx), s);
                    check(int'(phase_idx) == s % 5, "R4 phase is slot mod 5", int'(phase_idx), s % 5);
                    if (ifl) check(slot_ind == 1'b0, "R7 indication forced OFF", int'(slot_ind), 0);
                    else     check(slot_ind == pat_ind(f, s), "R5 indication from first bit",
                                   int'(slot_ind), int'(pat_ind(f, s)));
                end else begin
                    check(byte_valid == 1'b0, "R3 strobe only at slot end", int'(byte_valid), 0);
                end
            end
        end
    endtask

    initial begin
        #(200000 * 8);
        check(1'b0, "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1
        check(byte_valid == 1'b0, "R1 valid at reset", int'(byte_valid), 0);
        check(locked == 1'b0, "R1 locked at reset", int'(locked), 0);
        check(align_err == 1'b0, "R1 err at reset", int'(align_err), 0);
        @(negedge clk);
        rst_n = 1'b1;

        send_idle(10, 9, -1);
        check(locked == 1'b0, "R2 one marker does not lock", int'(locked), 0);
        send_frame(0, 1'b0, 1'b1, -1, 99, -1, 1'b0);
        check(locked == 1'b1, "R2 lock after second marker", int'(locked), 1);
        send_frame(1, 1'b1, 1'b1, -1, 99, -1, 1'b0);
        send_frame(2, 1'b1, 1'b1, -1, 3, 5, 1'b0);        // R6
        send_frame(3, 1'b1, 1'b1, -1, 99, -1, 1'b1);      // R7
        send_frame(4, 1'b1, 1'b1, 50, 99, -1, 1'b0);      // R8 stray marker
        check(locked == 1'b1, "R8 stray marker tolerated", int'(locked), 1);
        send_frame(5, 1'b1, 1'b0, -1, 99, -1, 1'b0);      // R8 one missing marker
        check(locked == 1'b1, "R8 good marker cleared count, one miss tolerated", int'(locked), 1);
        check(align_err == 1'b0, "R8 no error after one miss", int'(align_err), 0);
        send_frame(6, 1'b1, 1'b0, -1, 99, -1, 1'b0);      // R9 second miss
        check(locked == 1'b0, "R9 lock lost", int'(locked), 0);
        check(align_err == 1'b1, "R9 error raised", int'(align_err), 1);
        send_idle(41, 5, 40);                              // R10 restart at bit 40
        send_frame(7, 1'b0, 1'b1, -1, 99, -1, 1'b0);
        check(locked == 1'b1, "R10 relock from restarted marker", int'(locked), 1);
        check(align_err == 1'b1, "R9 error stays set", int'(align_err), 1);
        send_frame(8, 1'b1, 1'b1, -1, 99, -1, 1'b0);      // R2 alignment after relock

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule